// File: doc/BRIEF.md
# Multi-Slot Configuration Image Sequencer

This controller sits between a parallel flash and the configuration port of a programmable device. The flash is split into equal slots, and each slot starts at the slot index times the slot size. Slot 0 holds a permanent loader image. The remaining slots hold user images.

A loader button always selects slot 0. A user button selects the slot named by an external selector switch. The configured logic can also raise a chaining request, which moves a multi-stage job on to the image in the next slot. Once a load is accepted, the sequencer does the following:

- It pulses a start strobe to the device.
- It reads the slot word by word and streams the words to the device in address order.
- It waits a bounded time for the device's done indication.
- It holds the configured logic in reset for a fixed number of cycles, then releases it.

If a selection is invalid, no load starts and a sticky error flag is set. If done does not arrive in time, the sequencer stops with the configured logic still held in reset.

Top module: `cfg_slot_loader`

## Requirements
- R1: After reset, `user_rst_o` is 1 and `busy_o`, `err_sel_o`, `err_timeout_o`, `flash_rd_o` and `cfg_valid_o` are all 0.
- R2: A loader-button press loads slot 0. The sequencer pulses `cfg_start_o` once, then streams exactly IMAGE_WORDS words, one per `cfg_valid_o`. Word k is the flash word at address k. The flash returns data one cycle after `flash_rd_o`.
- R3: A user-button press with `slot_sel_i` in 1..NUM_SLOTS-1 streams IMAGE_WORDS words. Word k comes from flash address `slot_sel_i`*SLOT_WORDS + k. `cur_slot_o` then shows the selected slot.
- R4: A user-button press with `slot_sel_i` equal to 0 or to NUM_SLOTS or above starts no load. It sets `err_sel_o`, which stays 1 until reset, and a later valid load leaves it at 1.
- R5: A rising edge of `chain_req_i`, while the configured logic runs, loads slot `cur_slot_o`+1. When `cur_slot_o` is already the last slot, the request is rejected as in R4.
- R6: Button presses and chaining requests are ignored while `busy_o` is 1. `busy_o` covers streaming, waiting for done, and the reset pulse.
- R7: After `cfg_done_i` is first sampled high at a clock edge, `user_rst_o` is held at 1 and falls at the (RST_CYCLES+3)-th edge counted from that one. This is two synchroniser stages, one decision cycle and RST_CYCLES cycles of reset.
- R8: If done has not arrived DONE_TIMEOUT cycles after the last word, `err_timeout_o` rises, `busy_o` falls and `user_rst_o` stays 1. A late done has no effect. A new button press clears `err_timeout_o` and loads again.
- R9: If the loader and user buttons rise in the same cycle, the loader button wins and slot 0 is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| btn_loader_i | input | 1 | Debounced loader button, active high |
| btn_user_i | input | 1 | Debounced user-image button, active high |
| slot_sel_i | input | SEL_W | Slot chosen by the external selector switch |
| chain_req_i | input | 1 | Request from the configured logic to load the next slot |
| flash_rd_o | output | 1 | Flash read strobe |
| flash_addr_o | output | ADDR_W | Flash word address |
| flash_data_i | input | DATA_W | Flash read data, valid one cycle after the strobe |
| cfg_start_o | output | 1 | One-cycle strobe that clears the device before a load |
| cfg_valid_o | output | 1 | Configuration word valid |
| cfg_data_o | output | DATA_W | Configuration word |
| cfg_done_i | input | 1 | Done indication from the device, asynchronous |
| user_rst_o | output | 1 | Reset to the configured logic, active high |
| busy_o | output | 1 | A load, done wait or reset pulse is in progress |
| cur_slot_o | output | SLOT_W | Slot most recently selected for loading |
| err_sel_o | output | 1 | Sticky invalid-selection flag |
| err_timeout_o | output | 1 | Done timeout; configured logic stays in reset |

## Verification
The hardest states to reach from the ports come from requests that run into an edge of the sequencer's own lifetime. One is a chaining request made from the last slot. Another is a button press that lands in the middle of a stream. A third is a done indication that arrives only after the timeout has expired.

The bench reaches the first by walking the chain from slot 1 up to the last slot and then requesting once more. It reaches the second by pressing both buttons a few cycles into a slot-0 stream and checking every later word against slot 0. It reaches the third by withholding done and raising it only after the fault is reported. Invalid selections are swept after a reset each, so that the sticky flag is seen to rise from 0 every time.

// File: rtl/cfg_slot_pkg.sv
package cfg_slot_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_LOAD  = 3'd1,
        ST_WAIT  = 3'd2,
        ST_RSTP  = 3'd3,
        ST_RUN   = 3'd4,
        ST_FAULT = 3'd5
    } seq_state_e;

    // Which trigger caused an accepted request
    typedef enum logic [1:0] {
        TRG_NONE   = 2'd0,
        TRG_LOADER = 2'd1,
        TRG_USER   = 2'd2,
        TRG_CHAIN  = 2'd3
    } trig_src_e;

    // A user slot must be non-zero and inside the slot range
    function automatic logic user_slot_ok(input int unsigned sel, input int unsigned nslots);
        return (sel != 0) && (sel < nslots);
    endfunction

    // States in which a new request may be accepted
    function automatic logic state_accepts(input seq_state_e st);
        return (st == ST_IDLE) || (st == ST_RUN) || (st == ST_FAULT);
    endfunction

    function automatic logic state_busy(input seq_state_e st);
        return (st == ST_LOAD) || (st == ST_WAIT) || (st == ST_RSTP);
    endfunction

endpackage

// File: rtl/cfg_sync_edge.sv
module cfg_sync_edge #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] rise_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;
    logic [W-1:0] prev_q;

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                meta_q[i] <= 1'b0;
                sync_q[i] <= 1'b0;
                prev_q[i] <= 1'b0;
            end else begin
                meta_q[i] <= async_i[i];
                sync_q[i] <= meta_q[i];
                prev_q[i] <= sync_q[i];
            end
        end
        assign rise_o[i] = sync_q[i] & ~prev_q[i];
    end

endmodule

// File: rtl/cfg_trigger_sel.sv
module cfg_trigger_sel
    import cfg_slot_pkg::*;
#(
    parameter int NUM_SLOTS = 6,
    parameter int SEL_W     = 3,
    parameter int SLOT_W    = 3
) (
    input  seq_state_e        state_i,
    input  logic              ld_rise_i,
    input  logic              usr_rise_i,
    input  logic              chn_rise_i,
    input  logic [SEL_W-1:0]  sel_i,
    input  logic [SLOT_W-1:0] cur_slot_i,
    output logic              go_o,
    output logic              reject_o,
    output trig_src_e         src_o,
    output logic [SLOT_W-1:0] tgt_o
);
    logic              accept;
    logic              running;
    logic [SLOT_W:0]   next_slot;

    assign accept    = state_accepts(state_i);
    assign running   = (state_i == ST_RUN);
    assign next_slot = {1'b0, cur_slot_i} + (SLOT_W+1)'(1);

    // Priority: loader button, then user button, then chaining request
    always_comb begin
        go_o     = 1'b0;
        reject_o = 1'b0;
        src_o    = TRG_NONE;
        tgt_o    = '0;
        if (accept && ld_rise_i) begin
            go_o  = 1'b1;
            src_o = TRG_LOADER;
        end else if (accept && usr_rise_i) begin
            src_o = TRG_USER;
            if (user_slot_ok(32'(sel_i), NUM_SLOTS)) begin
                go_o  = 1'b1;
                tgt_o = sel_i[SLOT_W-1:0];
            end else begin
                reject_o = 1'b1;
            end
        end else if (running && chn_rise_i) begin
            src_o = TRG_CHAIN;
            if (32'(next_slot) < NUM_SLOTS) begin
                go_o  = 1'b1;
                tgt_o = next_slot[SLOT_W-1:0];
            end else begin
                reject_o = 1'b1;
            end
        end
    end

endmodule

// File: rtl/cfg_word_streamer.sv
module cfg_word_streamer #(
    parameter int ADDR_W      = 9,
    parameter int DATA_W      = 16,
    parameter int IMAGE_WORDS = 48
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] base_i,
    output logic              flash_rd_o,
    output logic [ADDR_W-1:0] flash_addr_o,
    input  logic [DATA_W-1:0] flash_data_i,
    output logic              cfg_valid_o,
    output logic [DATA_W-1:0] cfg_data_o,
    output logic              last_o
);
    localparam int CNT_W = $clog2(IMAGE_WORDS + 1);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(IMAGE_WORDS - 1);

    logic              active_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [ADDR_W-1:0] addr_q;
    logic              rd_d_q;
    logic              last_d_q;
    logic              valid_q;
    logic              last_q;
    logic [DATA_W-1:0] data_q;

    // Address stage
    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
            addr_q   <= '0;
        end else if (start_i) begin
            active_q <= 1'b1;
            cnt_q    <= '0;
            addr_q   <= base_i;
        end else if (active_q) begin
            if (cnt_q == LAST_IDX) begin
                active_q <= 1'b0;
            end else begin
                cnt_q  <= cnt_q + CNT_W'(1);
                addr_q <= addr_q + ADDR_W'(1);
            end
        end
    end

    // Flash latency stage, then output register
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_d_q   <= 1'b0;
            last_d_q <= 1'b0;
            valid_q  <= 1'b0;
            last_q   <= 1'b0;
            data_q   <= '0;
        end else begin
            rd_d_q   <= active_q;
            last_d_q <= active_q && (cnt_q == LAST_IDX);
            valid_q  <= rd_d_q;
            last_q   <= last_d_q;
            if (rd_d_q) begin
                data_q <= flash_data_i;
            end
        end
    end

    assign flash_rd_o   = active_q;
    assign flash_addr_o = addr_q;
    assign cfg_valid_o  = valid_q;
    assign cfg_data_o   = data_q;
    assign last_o       = valid_q & last_q;

endmodule

// File: rtl/cfg_slot_loader.sv
module cfg_slot_loader
    import cfg_slot_pkg::*;
#(
    parameter int NUM_SLOTS    = 6,
    parameter int SLOT_WORDS   = 4096,
    parameter int IMAGE_WORDS  = 4000,
    parameter int DATA_W       = 16,
    parameter int SEL_W        = 3,
    parameter int DONE_TIMEOUT = 1024,
    parameter int RST_CYCLES   = 16,
    localparam int SLOT_W      = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
    localparam int ADDR_W      = $clog2(NUM_SLOTS * SLOT_WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              btn_loader_i,
    input  logic              btn_user_i,
    input  logic [SEL_W-1:0]  slot_sel_i,
    input  logic              chain_req_i,
    output logic              flash_rd_o,
    output logic [ADDR_W-1:0] flash_addr_o,
    input  logic [DATA_W-1:0] flash_data_i,
    output logic              cfg_start_o,
    output logic              cfg_valid_o,
    output logic [DATA_W-1:0] cfg_data_o,
    input  logic              cfg_done_i,
    output logic              user_rst_o,
    output logic              busy_o,
    output logic [SLOT_W-1:0] cur_slot_o,
    output logic              err_sel_o,
    output logic              err_timeout_o
);
    localparam int TMO_W = $clog2(DONE_TIMEOUT + 1);
    localparam int RPC_W = $clog2(RST_CYCLES + 1);
    localparam logic [TMO_W-1:0]  TMO_LAST  = TMO_W'(DONE_TIMEOUT - 1);
    localparam logic [RPC_W-1:0]  RSTP_LAST = RPC_W'(RST_CYCLES - 1);
    localparam logic [ADDR_W-1:0] SLOT_SPAN = ADDR_W'(SLOT_WORDS);

    seq_state_e        state_q;
    logic [TMO_W-1:0]  tmo_q;
    logic [RPC_W-1:0]  rstp_q;
    logic [SLOT_W-1:0] slot_q;
    logic              err_sel_q;
    logic              start_q;
    logic [1:0]        done_sync_q;

    logic [2:0]        rise;
    logic              go;
    logic              reject;
    trig_src_e         src;
    logic [SLOT_W-1:0] tgt;
    logic [ADDR_W-1:0] base;
    logic              stream_last;
    logic              done_lvl;

    cfg_sync_edge #(.W(3)) i_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i ({chain_req_i, btn_user_i, btn_loader_i}),
        .rise_o  (rise)
    );

    cfg_trigger_sel #(
        .NUM_SLOTS (NUM_SLOTS),
        .SEL_W     (SEL_W),
        .SLOT_W    (SLOT_W)
    ) i_trig (
        .state_i    (state_q),
        .ld_rise_i  (rise[0]),
        .usr_rise_i (rise[1]),
        .chn_rise_i (rise[2]),
        .sel_i      (slot_sel_i),
        .cur_slot_i (slot_q),
        .go_o       (go),
        .reject_o   (reject),
        .src_o      (src),
        .tgt_o      (tgt)
    );

    assign base = ADDR_W'(tgt) * SLOT_SPAN;

    cfg_word_streamer #(
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W),
        .IMAGE_WORDS (IMAGE_WORDS)
    ) i_stream (
        .clk          (clk),
        .rst          (rst),
        .start_i      (go),
        .base_i       (base),
        .flash_rd_o   (flash_rd_o),
        .flash_addr_o (flash_addr_o),
        .flash_data_i (flash_data_i),
        .cfg_valid_o  (cfg_valid_o),
        .cfg_data_o   (cfg_data_o),
        .last_o       (stream_last)
    );

    // Done comes from the device domain
    always_ff @(posedge clk) begin
        if (rst) begin
            done_sync_q <= '0;
        end else begin
            done_sync_q <= {done_sync_q[0], cfg_done_i};
        end
    end
    assign done_lvl = done_sync_q[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            tmo_q     <= '0;
            rstp_q    <= '0;
            slot_q    <= '0;
            err_sel_q <= 1'b0;
            start_q   <= 1'b0;
        end else begin
            start_q <= 1'b0;
            if (reject) begin
                err_sel_q <= 1'b1;
            end
            unique case (state_q)
                ST_IDLE, ST_RUN, ST_FAULT: begin
                    if (go) begin
                        state_q <= ST_LOAD;
                        slot_q  <= tgt;
                        start_q <= (src != TRG_NONE);
                    end
                end
                ST_LOAD: begin
                    if (stream_last) begin
                        state_q <= ST_WAIT;
                        tmo_q   <= '0;
                    end
                end
                ST_WAIT: begin
                    if (done_lvl) begin
                        state_q <= ST_RSTP;
                        rstp_q  <= '0;
                    end else if (tmo_q == TMO_LAST) begin
                        state_q <= ST_FAULT;
                    end else begin
                        tmo_q <= tmo_q + TMO_W'(1);
                    end
                end
                ST_RSTP: begin
                    if (rstp_q == RSTP_LAST) begin
                        state_q <= ST_RUN;
                    end else begin
                        rstp_q <= rstp_q + RPC_W'(1);
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign cfg_start_o   = start_q;
    assign user_rst_o    = (state_q != ST_RUN);
    assign busy_o        = state_busy(state_q);
    assign cur_slot_o    = slot_q;
    assign err_sel_o     = err_sel_q;
    assign err_timeout_o = (state_q == ST_FAULT);

endmodule

// File: rtl/cfg_slot_checker.sv
module cfg_slot_checker
    import cfg_slot_pkg::*;
#(
    parameter int NUM_SLOTS   = 6,
    parameter int SLOT_WORDS  = 4096,
    parameter int IMAGE_WORDS = 4000,
    parameter int RST_CYCLES  = 16,
    parameter int SLOT_W      = 3,
    parameter int ADDR_W      = 15
) (
    input logic              clk,
    input logic              rst,
    input logic              flash_rd_o,
    input logic [ADDR_W-1:0] flash_addr_o,
    input logic              cfg_start_o,
    input logic              cfg_valid_o,
    input logic              user_rst_o,
    input logic              busy_o,
    input logic [SLOT_W-1:0] cur_slot_o,
    input logic              err_sel_o,
    input logic              err_timeout_o,
    input seq_state_e        state_q
);
    logic [15:0] rstp_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            rstp_cnt <= '0;
        end else if (state_q == ST_RSTP) begin
            rstp_cnt <= rstp_cnt + 16'd1;
        end else begin
            rstp_cnt <= '0;
        end
    end

    AST_VALID_NEEDS_BUSY: assert property (@(posedge clk) disable iff (rst)
        cfg_valid_o |-> busy_o); // R2

    AST_ADDR_IN_SLOT: assert property (@(posedge clk) disable iff (rst)
        flash_rd_o |-> ((int'(flash_addr_o) >= int'(cur_slot_o) * SLOT_WORDS) &&
                        (int'(flash_addr_o) <  int'(cur_slot_o) * SLOT_WORDS + IMAGE_WORDS))); // R3

    AST_SEL_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        err_sel_o |=> err_sel_o); // R4

    AST_START_WHEN_FREE: assert property (@(posedge clk) disable iff (rst)
        cfg_start_o |-> !$past(busy_o)); // R6

    AST_RST_PULSE_LEN: assert property (@(posedge clk) disable iff (rst)
        $fell(user_rst_o) |-> (int'(rstp_cnt) == RST_CYCLES)); // R7

    AST_FAULT_HOLDS_RST: assert property (@(posedge clk) disable iff (rst)
        err_timeout_o |-> (user_rst_o && !busy_o)); // R8

endmodule

bind cfg_slot_loader cfg_slot_checker #(
    .NUM_SLOTS   (NUM_SLOTS),
    .SLOT_WORDS  (SLOT_WORDS),
    .IMAGE_WORDS (IMAGE_WORDS),
    .RST_CYCLES  (RST_CYCLES),
    .SLOT_W      (SLOT_W),
    .ADDR_W      (ADDR_W)
) i_chk (
    .clk           (clk),
    .rst           (rst),
    .flash_rd_o    (flash_rd_o),
    .flash_addr_o  (flash_addr_o),
    .cfg_start_o   (cfg_start_o),
    .cfg_valid_o   (cfg_valid_o),
    .user_rst_o    (user_rst_o),
    .busy_o        (busy_o),
    .cur_slot_o    (cur_slot_o),
    .err_sel_o     (err_sel_o),
    .err_timeout_o (err_timeout_o),
    .state_q       (state_q)
);

// File: tb/test_cfg_slot_loader.sv
module test_cfg_slot_loader;
    localparam int NS   = 6;
    localparam int SW   = 16;
    localparam int IMG  = 12;
    localparam int DW   = 16;
    localparam int SELW = 3;
    localparam int TMO  = 20;
    localparam int RSTC = 16;
    localparam int SLW  = $clog2(NS);
    localparam int AW   = $clog2(NS * SW);

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            btn_ld = 1'b0;
    logic            btn_us = 1'b0;
    logic [SELW-1:0] sel = '0;
    logic            chain = 1'b0;
    logic            flash_rd_o;
    logic [AW-1:0]   flash_addr_o;
    logic [DW-1:0]   flash_data_i = '0;
    logic            cfg_start_o;
    logic            cfg_valid_o;
    logic [DW-1:0]   cfg_data_o;
    logic            cfg_done_i = 1'b0;
    logic            user_rst_o;
    logic            busy_o;
    logic [SLW-1:0]  cur_slot_o;
    logic            err_sel_o;
    logic            err_timeout_o;

    int    checks = 0;
    int    errors = 0;
    int    word_idx = 0;
    int    starts = 0;
    int    exp_base = 0;
    bit    finished = 1'b0;
    string cur_req = "R2";

    always #5 clk = ~clk;

    cfg_slot_loader #(
        .NUM_SLOTS (NS), .SLOT_WORDS (SW), .IMAGE_WORDS (IMG), .DATA_W (DW),
        .SEL_W (SELW), .DONE_TIMEOUT (TMO), .RST_CYCLES (RSTC)
    ) i_cfg_slot_loader (
        .clk (clk), .rst (rst), .btn_loader_i (btn_ld), .btn_user_i (btn_us),
        .slot_sel_i (sel), .chain_req_i (chain), .flash_rd_o (flash_rd_o),
        .flash_addr_o (flash_addr_o), .flash_data_i (flash_data_i),
        .cfg_start_o (cfg_start_o), .cfg_valid_o (cfg_valid_o), .cfg_data_o (cfg_data_o),
        .cfg_done_i (cfg_done_i), .user_rst_o (user_rst_o), .busy_o (busy_o),
        .cur_slot_o (cur_slot_o), .err_sel_o (err_sel_o), .err_timeout_o (err_timeout_o)
    );

    function automatic logic [DW-1:0] fword(input int a);
        logic [31:0] t;
        t = 32'(a) * 32'd40503 + 32'd4660;
        return t[DW-1:0];
    endfunction

    task automatic check(input bit ok, input string req, input longint act,
                         input longint exp, input string what);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Flash with one cycle of read latency
    initial forever begin
        @(posedge clk);
        if (flash_rd_o) flash_data_i <= fword(int'(flash_addr_o));
    end

    // Stream and start monitor
    initial forever begin
        @(negedge clk);
        if (cfg_start_o) starts++;
        if (cfg_valid_o) begin
            check(word_idx < IMG, cur_req, word_idx, IMG - 1, "word count");
            check(cfg_data_o == fword(exp_base + word_idx), cur_req,
                  cfg_data_o, fword(exp_base + word_idx), "stream word");
            word_idx++;
        end
    end

    task automatic prep(input int slot, input string req);
        exp_base   = slot * SW;
        word_idx   = 0;
        starts     = 0;
        cur_req    = req;
        cfg_done_i = 1'b0;
    endtask

    task automatic press(input bit l, input bit u, input bit c);
        @(negedge clk);
        btn_ld = l; btn_us = u; chain = c;
        repeat (4) @(negedge clk);
        btn_ld = 1'b0; btn_us = 1'b0; chain = 1'b0;
    endtask

    task automatic wait_words();
        int g;
        g = 0;
        while (word_idx < IMG && g < 300) begin
            @(negedge clk);
            g++;
        end
    endtask

    task automatic finish_load(input int slot, input string req);
        int n;
        wait_words();
        check(word_idx == IMG, req, word_idx, IMG, "words streamed");
        check(starts == 1, req, starts, 1, "start strobes");
        check(int'(cur_slot_o) == slot, req, cur_slot_o, slot, "current slot");
        repeat (3) @(negedge clk);
        check(busy_o && user_rst_o, req, busy_o, 1, "busy while waiting done");
        cfg_done_i = 1'b1;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (user_rst_o && n < 100);
        check(n == RSTC + 3, "R7", n, RSTC + 3, "reset release edge");
        check(!busy_o, "R7", busy_o, 0, "idle after reset pulse");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(user_rst_o == 1'b1, "R1", user_rst_o, 1, "user reset");
        check(!busy_o, "R1", busy_o, 0, "busy");
        check(!err_sel_o && !err_timeout_o, "R1", {err_sel_o, err_timeout_o}, 0, "errors");
        check(!flash_rd_o && !cfg_valid_o, "R1", {flash_rd_o, cfg_valid_o}, 0, "activity");

        // R2 loader slot
        prep(0, "R2");
        press(1'b1, 1'b0, 1'b0);
        finish_load(0, "R2");

        // R3 every user slot
        for (int s = 1; s < NS; s++) begin
            prep(s, "R3");
            sel = SELW'(s);
            press(1'b0, 1'b1, 1'b0);
            finish_load(s, "R3");
            check(!err_sel_o, "R3", err_sel_o, 0, "no selection error");
        end

        // R5 chain through all slots
        prep(1, "R5");
        sel = SELW'(1);
        press(1'b0, 1'b1, 1'b0);
        finish_load(1, "R5");
        for (int s = 2; s < NS; s++) begin
            prep(s, "R5");
            press(1'b0, 1'b0, 1'b1);
            finish_load(s, "R5");
        end
        prep(0, "R5");
        press(1'b0, 1'b0, 1'b1);
        repeat (15) @(negedge clk);
        check(starts == 0, "R5", starts, 0, "chain past last slot starts nothing");
        check(err_sel_o, "R5", err_sel_o, 1, "chain past last slot flags error");
        check(!user_rst_o, "R5", user_rst_o, 0, "running image undisturbed");

        // R4 invalid selections, each after a reset
        for (int v = 0; v < 8; v++) begin
            if (v == 0 || v >= NS) begin
                rst = 1'b1;
                repeat (2) @(negedge clk);
                rst = 1'b0;
                prep(0, "R4");
                sel = SELW'(v);
                press(1'b0, 1'b1, 1'b0);
                repeat (15) @(negedge clk);
                check(starts == 0 && !busy_o, "R4", starts, 0, "rejected selection starts nothing");
                check(err_sel_o, "R4", err_sel_o, 1, "selection error set");
            end
        end
        prep(0, "R4");
        press(1'b1, 1'b0, 1'b0);
        finish_load(0, "R4");
        check(err_sel_o, "R4", err_sel_o, 1, "selection error sticky");

        // R6 presses during a load are ignored
        prep(0, "R6");
        press(1'b1, 1'b0, 1'b0);
        check(busy_o, "R6", busy_o, 1, "load in progress");
        sel = SELW'(3);
        press(1'b1, 1'b1, 1'b1);
        finish_load(0, "R6");
        repeat (20) @(negedge clk);
        check(starts == 1, "R6", starts, 1, "no second load");
        check(int'(cur_slot_o) == 0 && !busy_o, "R6", cur_slot_o, 0, "slot kept");

        // R9 both buttons together
        prep(0, "R9");
        sel = SELW'(2);
        press(1'b1, 1'b1, 1'b0);
        finish_load(0, "R9");

        // R8 done timeout
        prep(1, "R8");
        sel = SELW'(1);
        press(1'b0, 1'b1, 1'b0);
        wait_words();
        repeat (30) @(negedge clk);
        check(err_timeout_o, "R8", err_timeout_o, 1, "timeout flagged");
        check(user_rst_o && !busy_o, "R8", {user_rst_o, busy_o}, 2, "reset held, not busy");
        cfg_done_i = 1'b1;
        repeat (10) @(negedge clk);
        check(user_rst_o && err_timeout_o, "R8", {user_rst_o, err_timeout_o}, 3, "late done ignored");
        prep(0, "R8");
        press(1'b1, 1'b0, 1'b0);
        finish_load(0, "R8");
        check(!err_timeout_o, "R8", err_timeout_o, 0, "timeout cleared by new load");

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule